// File: doc/BRIEF.md
# Pixel Input Formatter with Color Table

This block takes one 24-bit pixel word per clock, along with an 8-bit format code, and turns it into three 8-bit output components. It unpacks the word into three components according to the code. In palette (color-index) mode a single byte, first ANDed with a programmable mask, addresses all three channels of a 256-entry table and yields a 24-bit color. In the direct RGB, GBR, 15-bit and YCbCr modes, each component addresses its own channel of the same table. That channel then serves as a per-component correction curve for offset, gain and gamma.

Alongside the pixel, the block reports two flags to the later stages. One says whether the color-space matrix that follows must be bypassed, because the input is already luma/chroma. The other says whether the chroma byte is time-multiplexed 4:2:2.

A small byte-wide host port loads and reads back the table and the mask. It works like a classic palette DAC: an address is written first, then red, green and blue bytes follow, and the address steps by itself after each complete entry.

Top module: `pixfmt_clut`

## Requirements
- R1: After reset, `out_valid_o`, `bypass_o`, `chroma422_o` and `host_rdata_o` are 0, and a host read of the mask (select 2) returns 8'hFF.
- R2: Format code 8'h10 takes R from bits 23:16, G from 15:8 and B from 7:0. The output is {T0[R], T1[G], T2[B]} on `out_pix_o`, where T0, T1 and T2 are the three table channels. It appears two clock edges after the input is sampled, and `out_valid_o` follows `pix_valid_i` with the same two-edge delay.
- R3: Format code 8'h18 takes G from bits 23:16, B from 15:8 and R from 7:0, and the output is ordered as in R2.
- R4: Format code 8'h1C takes Y, Cb and Cr from the high, middle and low bytes. The output is {T0[Y], T1[Cb], T2[Cr]} with `bypass_o`=1 and `chroma422_o`=0.
- R5: Format code 8'h1D takes Y from bits 23:16 and the multiplexed chroma byte from bits 15:8. The output is {T0[Y], T1[C], 8'h00} with `bypass_o`=1 and `chroma422_o`=1.
- R6: Any format code matching 0001?011 (bit 3 ignored) selects palette mode. The index bits 7:0 are ANDed with the mask to form I, and the output is {T0[I], T1[I], T2[I]}.
- R7: The mask has no effect in every mode other than palette mode.
- R8: Format code 8'h12 takes 5-bit R, G and B from bits 14:10, 9:5 and 4:0. Format code 8'h1A takes 5-bit G, B and R from those same fields. Each 5-bit field f becomes {f, f[4:2]} before its table lookup.
- R9: Host writes use `host_sel_i` 0 to load the write address and 1 to send data bytes. The third data byte commits {byte1, byte2, byte3} to T0, T1 and T2 at that address, and the address then increments, wrapping from 255 to 0.
- R10: Host reads use select 3 to load the read address. Reads with select 1 return T0, T1 and T2 of that address in turn, then increment it with the same wrap. Read data appears one edge after `host_rd_en_i` and is otherwise held.
- R11: A host write with select 2 sets the mask, and a host read with select 2 returns it.
- R12: A format code not listed in R2 to R8 is unpacked as in R2, with `bypass_o`=0 and `chroma422_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid_i | input | 1 | Pixel word qualifier |
| pix_data_i | input | 24 | Packed pixel word |
| fmt_i | input | 8 | Format code |
| host_wr_en_i | input | 1 | Host write strobe |
| host_rd_en_i | input | 1 | Host read strobe |
| host_sel_i | input | 2 | Host register select: 0 write address, 1 data, 2 mask, 3 read address |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte |
| out_valid_o | output | 1 | Output qualifier |
| out_pix_o | output | 24 | Three output components, first component in the top byte |
| bypass_o | output | 1 | Input is luma/chroma, so the matrix must be skipped |
| chroma422_o | output | 1 | Middle component carries multiplexed 4:2:2 chroma |

## Verification
Pixel results, meaning data, valid and both flags, appear two edges after the pixel is sampled. The streaming loop drives a new word each cycle on the falling edge, and at each falling edge it checks the word issued two cycles before, so back-to-back words with changing formats are also covered. Host read data is due one edge after the strobe and is checked at the next falling edge. A committed table entry is visible to a read issued in the following cycle. Expected values come from a model of the table that the bench builds from the bytes it writes.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

   typedef enum logic [2:0] {
      MODE_RGB,
      MODE_GBR,
      MODE_YC444,
      MODE_YC422,
      MODE_INDEX,
      MODE_RGB15,
      MODE_GBR15
   } pix_mode_e;

   typedef enum logic [1:0] {
      HSEL_WPTR = 2'd0,
      HSEL_DATA = 2'd1,
      HSEL_MASK = 2'd2,
      HSEL_RPTR = 2'd3
   } host_sel_e;

   function automatic pix_mode_e decode_fmt(input logic [7:0] code);
      pix_mode_e m;
      casez (code)
         8'b0001_0000: m = MODE_RGB;
         8'b0001_1000: m = MODE_GBR;
         8'b0001_1100: m = MODE_YC444;
         8'b0001_1101: m = MODE_YC422;
         8'b0001_?011: m = MODE_INDEX;
         8'b0001_0010: m = MODE_RGB15;
         8'b0001_1010: m = MODE_GBR15;
         default:      m = MODE_RGB;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pixfmt_unpack.sv
module pixfmt_unpack
   import pixfmt_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  valid_i,
   input  logic [3*COMP_W-1:0]   data_i,
   input  logic [7:0]            fmt_i,
   input  logic [COMP_W-1:0]     mask_i,
   output logic                  valid_o,
   output logic [3*COMP_W-1:0]   comp_o,
   output logic                  bypass_o,
   output logic                  c422_o
);
   localparam int PIX_W = 3 * COMP_W;
   localparam int FLD_W = COMP_W - 3;

   pix_mode_e           mode;
   logic [COMP_W-1:0]   b_hi, b_mid, b_lo, idx;
   logic [COMP_W-1:0]   n_hi, n_mid, n_lo;
   logic [PIX_W-1:0]    comp_d;

   function automatic logic [COMP_W-1:0] widen(input logic [FLD_W-1:0] f);
      return {f, f[FLD_W-1 -: 3]};
   endfunction

   always_comb begin
      mode  = decode_fmt(fmt_i);
      b_hi  = data_i[PIX_W-1 -: COMP_W];
      b_mid = data_i[2*COMP_W-1 -: COMP_W];
      b_lo  = data_i[COMP_W-1:0];
      n_hi  = widen(data_i[3*FLD_W-1 -: FLD_W]);
      n_mid = widen(data_i[2*FLD_W-1 -: FLD_W]);
      n_lo  = widen(data_i[FLD_W-1:0]);
      idx   = b_lo & mask_i;
      unique case (mode)
         MODE_GBR:   comp_d = {b_lo, b_hi, b_mid};
         MODE_YC422: comp_d = {b_hi, b_mid, {COMP_W{1'b0}}};
         MODE_INDEX: comp_d = {idx, idx, idx};
         MODE_RGB15: comp_d = {n_hi, n_mid, n_lo};
         MODE_GBR15: comp_d = {n_lo, n_hi, n_mid};
         default:    comp_d = {b_hi, b_mid, b_lo};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         comp_o   <= '0;
         bypass_o <= 1'b0;
         c422_o   <= 1'b0;
      end else begin
         valid_o  <= valid_i;
         comp_o   <= comp_d;
         bypass_o <= (mode == MODE_YC444) || (mode == MODE_YC422);
         c422_o   <= (mode == MODE_YC422);
      end
   end

endmodule

// File: rtl/pixfmt_lut.sv
module pixfmt_lut #(
   parameter int COMP_W = 8
) (
   input  logic                  clk,
   input  logic                  wr_en_i,
   input  logic [COMP_W-1:0]     wr_addr_i,
   input  logic [3*COMP_W-1:0]   wr_data_i,
   input  logic [3*COMP_W-1:0]   rd_addr_i,
   output logic [3*COMP_W-1:0]   rd_data_o,
   input  logic [COMP_W-1:0]     host_addr_i,
   output logic [3*COMP_W-1:0]   host_data_o
);
   localparam int DEPTH = 1 << COMP_W;
   localparam int NCH   = 3;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      localparam int HI = (NCH - ch) * COMP_W - 1;
      logic [COMP_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en_i) mem[wr_addr_i] <= wr_data_i[HI -: COMP_W];
         rd_data_o[HI -: COMP_W] <= mem[rd_addr_i[HI -: COMP_W]];
      end

      assign host_data_o[HI -: COMP_W] = mem[host_addr_i];
   end

endmodule

// File: rtl/pixfmt_host.sv
module pixfmt_host
   import pixfmt_pkg::*;
#(
   parameter int              COMP_W   = 8,
   parameter logic [COMP_W-1:0] MASK_RST = '1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en_i,
   input  logic                  rd_en_i,
   input  logic [1:0]            sel_i,
   input  logic [COMP_W-1:0]     wdata_i,
   output logic [COMP_W-1:0]     rdata_o,
   output logic [COMP_W-1:0]     mask_o,
   output logic                  lut_we_o,
   output logic [COMP_W-1:0]     lut_waddr_o,
   output logic [3*COMP_W-1:0]   lut_wdata_o,
   output logic [COMP_W-1:0]     lut_raddr_o,
   input  logic [3*COMP_W-1:0]   lut_rdata_i
);
   localparam int LAST = 2;

   host_sel_e          sel;
   logic [COMP_W-1:0]  wptr, rptr, hold_r, hold_g;
   logic [1:0]         wcnt, rcnt;

   assign sel         = host_sel_e'(sel_i);
   assign lut_we_o    = wr_en_i && (sel == HSEL_DATA) && (wcnt == 2'(LAST));
   assign lut_waddr_o = wptr;
   assign lut_wdata_o = {hold_r, hold_g, wdata_i};
   assign lut_raddr_o = rptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         wcnt    <= '0;
         rcnt    <= '0;
         hold_r  <= '0;
         hold_g  <= '0;
         mask_o  <= MASK_RST;
         rdata_o <= '0;
      end else begin
         if (rd_en_i) begin
            unique case (sel)
               HSEL_WPTR: rdata_o <= wptr;
               HSEL_MASK: rdata_o <= mask_o;
               HSEL_RPTR: rdata_o <= rptr;
               HSEL_DATA: begin
                  rdata_o <= lut_rdata_i[(3 - int'(rcnt)) * COMP_W - 1 -: COMP_W];
                  if (rcnt == 2'(LAST)) begin
                     rcnt <= '0;
                     rptr <= rptr + 1'b1;
                  end else begin
                     rcnt <= rcnt + 1'b1;
                  end
               end
            endcase
         end
         if (wr_en_i) begin
            unique case (sel)
               HSEL_WPTR: begin wptr <= wdata_i; wcnt <= '0; end
               HSEL_MASK: mask_o <= wdata_i;
               HSEL_RPTR: begin rptr <= wdata_i; rcnt <= '0; end
               HSEL_DATA: begin
                  if (wcnt == 2'(LAST)) begin
                     wcnt <= '0;
                     wptr <= wptr + 1'b1;
                  end else begin
                     wcnt <= wcnt + 1'b1;
                     if (wcnt == 2'd0) hold_r <= wdata_i;
                     else              hold_g <= wdata_i;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/pixfmt_clut.sv
module pixfmt_clut #(
   parameter int COMP_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pix_valid_i,
   input  logic [3*COMP_W-1:0]   pix_data_i,
   input  logic [7:0]            fmt_i,
   input  logic                  host_wr_en_i,
   input  logic                  host_rd_en_i,
   input  logic [1:0]            host_sel_i,
   input  logic [COMP_W-1:0]     host_wdata_i,
   output logic [COMP_W-1:0]     host_rdata_o,
   output logic                  out_valid_o,
   output logic [3*COMP_W-1:0]   out_pix_o,
   output logic                  bypass_o,
   output logic                  chroma422_o
);
   localparam int PIX_W = 3 * COMP_W;

   if (COMP_W != 8) begin : g_bad_width
      $error("pixfmt_clut: format codes assume byte-wide components");
   end

   logic                mask_valid_unused;
   logic [COMP_W-1:0]   mask;
   logic                s1_valid, s1_bypass, s1_c422;
   logic [PIX_W-1:0]    s1_comp, lut_q, host_rd_word;
   logic                lut_we;
   logic [COMP_W-1:0]   lut_waddr, lut_raddr;
   logic [PIX_W-1:0]    lut_wdata;

   assign mask_valid_unused = 1'b0;

   pixfmt_host #(.COMP_W(COMP_W)) i_host (
      .clk, .rst_n,
      .wr_en_i     (host_wr_en_i),
      .rd_en_i     (host_rd_en_i),
      .sel_i       (host_sel_i),
      .wdata_i     (host_wdata_i),
      .rdata_o     (host_rdata_o),
      .mask_o      (mask),
      .lut_we_o    (lut_we),
      .lut_waddr_o (lut_waddr),
      .lut_wdata_o (lut_wdata),
      .lut_raddr_o (lut_raddr),
      .lut_rdata_i (host_rd_word)
   );

   pixfmt_unpack #(.COMP_W(COMP_W)) i_unpack (
      .clk, .rst_n,
      .valid_i  (pix_valid_i),
      .data_i   (pix_data_i),
      .fmt_i    (fmt_i),
      .mask_i   (mask),
      .valid_o  (s1_valid),
      .comp_o   (s1_comp),
      .bypass_o (s1_bypass),
      .c422_o   (s1_c422)
   );

   pixfmt_lut #(.COMP_W(COMP_W)) i_lut (
      .clk,
      .wr_en_i     (lut_we),
      .wr_addr_i   (lut_waddr),
      .wr_data_i   (lut_wdata),
      .rd_addr_i   (s1_comp),
      .rd_data_o   (lut_q),
      .host_addr_i (lut_raddr),
      .host_data_o (host_rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         bypass_o    <= 1'b0;
         chroma422_o <= 1'b0;
      end else begin
         out_valid_o <= s1_valid;
         bypass_o    <= s1_bypass;
         chroma422_o <= s1_c422;
      end
   end

   assign out_pix_o = chroma422_o ? {lut_q[PIX_W-1:COMP_W], {COMP_W{mask_valid_unused}}}
                                  : lut_q;

endmodule

// File: rtl/pixfmt_clut_chk.sv
module pixfmt_clut_chk #(
   parameter int COMP_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 pix_valid_i,
   input logic [7:0]           fmt_i,
   input logic                 host_rd_en_i,
   input logic [COMP_W-1:0]    host_rdata_o,
   input logic                 out_valid_o,
   input logic [3*COMP_W-1:0]  out_pix_o,
   input logic                 bypass_o,
   input logic                 chroma422_o
);
   AST_VALID_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> $past(pix_valid_i, 2)); // R2

   AST_BYPASS_FROM_YC: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && bypass_o) |-> ($past(fmt_i[7:1], 2) == 7'b0001110)); // R4

   AST_C422_FROM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && chroma422_o) |-> ($past(fmt_i, 2) == 8'h1D)); // R5

   AST_C422_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && chroma422_o) |-> (out_pix_o[COMP_W-1:0] == '0)); // R5

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(host_rd_en_i) |-> $stable(host_rdata_o)); // R10
endmodule

bind pixfmt_clut pixfmt_clut_chk #(.COMP_W(COMP_W)) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pix_valid_i  (pix_valid_i),
   .fmt_i        (fmt_i),
   .host_rd_en_i (host_rd_en_i),
   .host_rdata_o (host_rdata_o),
   .out_valid_o  (out_valid_o),
   .out_pix_o    (out_pix_o),
   .bypass_o     (bypass_o),
   .chroma422_o  (chroma422_o)
);

// File: tb/test_pixfmt_clut.sv
module test_pixfmt_clut;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid_i = 1'b0;
   logic [23:0] pix_data_i = '0;
   logic [7:0]  fmt_i = '0;
   logic        host_wr_en_i = 1'b0;
   logic        host_rd_en_i = 1'b0;
   logic [1:0]  host_sel_i = '0;
   logic [7:0]  host_wdata_i = '0;
   logic [7:0]  host_rdata_o;
   logic        out_valid_o;
   logic [23:0] out_pix_o;
   logic        bypass_o;
   logic        chroma422_o;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] m0 [256];
   logic [7:0] m1 [256];
   logic [7:0] m2 [256];
   logic [7:0] mask_m = 8'hFF;

   always #10 clk = ~clk;

   pixfmt_clut i_pixfmt_clut (.*);

   typedef struct packed {
      logic       v;
      logic [7:0] fmt;
      logic [23:0] data;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h10, 24'h123456},   // R2
      '{1'b1, 8'h18, 24'hA1B2C3},   // R3
      '{1'b1, 8'h1C, 24'h8040C0},   // R4
      '{1'b1, 8'h1D, 24'h556677},   // R5
      '{1'b1, 8'h13, 24'h0000F7},   // R6
      '{1'b1, 8'h1B, 24'hFFFF4A},   // R6 bit 3 ignored
      '{1'b1, 8'h12, 24'h005A3C},   // R8
      '{1'b1, 8'h1A, 24'h0012AB},   // R8
      '{1'b1, 8'h10, 24'h0000FF},   // R7
      '{1'b1, 8'hFF, 24'h0A0B0C},   // R12
      '{1'b0, 8'h10, 24'h777777},   // R2 valid low
      '{1'b1, 8'h03, 24'hC0FFEE}    // R12
   };

   function automatic logic [7:0] f0(input int a); return 8'(a) ^ 8'h3C; endfunction
   function automatic logic [7:0] f1(input int a); return 8'(a + 17); endfunction
   function automatic logic [7:0] f2(input int a); return ~8'(a); endfunction
   function automatic logic [7:0] x5(input logic [4:0] f); return {f, f[4:2]}; endfunction

   // {bypass, chroma422, pixel}
   function automatic logic [25:0] expect_pix(input logic [7:0] fm, input logic [23:0] d,
                                              input logic [7:0] mk);
      logic [7:0] r, g, b;
      logic byp, c4;
      byp = 1'b0; c4 = 1'b0;
      r = d[23:16]; g = d[15:8]; b = d[7:0];
      if (fm == 8'h18) begin
         g = d[23:16]; b = d[15:8]; r = d[7:0];
      end else if (fm == 8'h1C) begin
         byp = 1'b1;
      end else if (fm == 8'h1D) begin
         byp = 1'b1; c4 = 1'b1;
      end else if ((fm & 8'hF7) == 8'h13) begin
         r = d[7:0] & mk; g = r; b = r;
      end else if (fm == 8'h12) begin
         r = x5(d[14:10]); g = x5(d[9:5]); b = x5(d[4:0]);
      end else if (fm == 8'h1A) begin
         g = x5(d[14:10]); b = x5(d[9:5]); r = x5(d[4:0]);
      end
      return {byp, c4, m0[r], m1[g], c4 ? 8'h00 : m2[b]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [1:0] s, input logic [7:0] d);
      host_wr_en_i = 1'b1; host_sel_i = s; host_wdata_i = d;
      @(negedge clk);
      host_wr_en_i = 1'b0;
   endtask

   task automatic hrd(input logic [1:0] s, input logic [7:0] exp, input string req);
      host_rd_en_i = 1'b1; host_sel_i = s;
      @(negedge clk);
      host_rd_en_i = 1'b0;
      check(host_rdata_o == exp, req, 32'(host_rdata_o), 32'(exp));
   endtask

   task automatic put_entry(input int a, input logic [7:0] r, input logic [7:0] g,
                            input logic [7:0] b);
      hwr(2'd1, r); hwr(2'd1, g); hwr(2'd1, b);
      m0[a] = r; m1[a] = g; m2[a] = b;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!out_valid_o && !bypass_o && !chroma422_o, "R1 flags", 
            {29'd0, out_valid_o, bypass_o, chroma422_o}, 32'd0);
      check(host_rdata_o == 8'h00, "R1 rdata", 32'(host_rdata_o), 32'd0);
      hrd(2'd2, 8'hFF, "R1 mask reset");

      // R9 fill the whole table from address 0 with auto-increment
      hwr(2'd0, 8'd0);
      for (int a = 0; a < 256; a++) put_entry(a, f0(a), f1(a), f2(a));
      // R9 pointer wrapped from 255 to 0: next entry lands on 0
      put_entry(0, 8'hA1, 8'hB2, 8'hC3);
      hwr(2'd3, 8'd0);
      hrd(2'd1, 8'hA1, "R9 wrap T0");
      hrd(2'd1, 8'hB2, "R9 wrap T1");
      hrd(2'd1, 8'hC3, "R9 wrap T2");
      // R10 read wrap from 255 to 0
      hwr(2'd3, 8'd255);
      hrd(2'd1, m0[255], "R10 T0");
      hrd(2'd1, m1[255], "R10 T1");
      hrd(2'd1, m2[255], "R10 T2");
      hrd(2'd1, m0[0], "R10 wrap");
      hrd(2'd3, 8'd0, "R10 read pointer");
      // R11 mask write and read back
      hwr(2'd2, 8'h3F); mask_m = 8'h3F;
      hrd(2'd2, 8'h3F, "R11 mask");

      // streaming vectors, one per cycle, each checked two edges later
      for (int i = 0; i < NV + 2; i++) begin
         if (i >= 2) begin
            vec_t vv;
            logic [25:0] e;
            vv = VECS[i-2];
            e = expect_pix(vv.fmt, vv.data, mask_m);
            if (vv.v)
               check(out_valid_o && {bypass_o, chroma422_o, out_pix_o} == e,
                     $sformatf("R2-path vec %0d fmt %h", i-2, vv.fmt),
                     {5'd0, out_valid_o, bypass_o, chroma422_o, out_pix_o},
                     {6'd1, e});
            else
               check(!out_valid_o, "R2 valid low", 32'(out_valid_o), 32'd0);
         end
         if (i < NV) begin
            pix_valid_i = VECS[i].v; fmt_i = VECS[i].fmt; pix_data_i = VECS[i].data;
         end else begin
            pix_valid_i = 1'b0;
         end
         @(negedge clk);
      end

      // R6 mask zero forces index 0; R7 same mask leaves RGB intact
      hwr(2'd2, 8'h00); mask_m = 8'h00;
      pix_valid_i = 1'b1; fmt_i = 8'h13; pix_data_i = 24'h0000C5;
      @(negedge clk); pix_valid_i = 1'b0; @(negedge clk);
      check(out_pix_o == {m0[0], m1[0], m2[0]}, "R6 mask zero",
            32'(out_pix_o), 32'({m0[0], m1[0], m2[0]}));
      pix_valid_i = 1'b1; fmt_i = 8'h10; pix_data_i = 24'h0102C5;
      @(negedge clk); pix_valid_i = 1'b0; @(negedge clk);
      check(out_pix_o == {m0[1], m1[2], m2[8'hC5]}, "R7 mask ignored",
            32'(out_pix_o), 32'({m0[1], m1[2], m2[8'hC5]}));

      // R9 commit only after third byte: two bytes leave entry untouched
      hwr(2'd0, 8'd9);
      hwr(2'd1, 8'h11); hwr(2'd1, 8'h22);
      hwr(2'd3, 8'd9);
      hrd(2'd1, m0[9], "R9 no early commit");

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule